// File: doc/BRIEF.md
# Scan Pacing and Clock Gating Sequencer

This block paces a multi-channel acquisition. Once armed by a start trigger, it waits for a sample-clock pulse. It then emits one convert pulse for each channel in the scan, each tagged with a channel index. The first convert comes a programmable number of timebase ticks after the accepted sample pulse. Later converts are spaced by a programmable period, also counted in ticks. A sample-done pulse marks the last convert of the scan.

The block enforces strict ordering between sample and convert activity. A sample pulse that arrives before the trigger, or while a scan is still in progress, is dropped. The same applies to an external convert pulse that arrives outside a scan, or when the internal pacer is in charge. Each dropped pulse raises a one-cycle flag.

A source select chooses the convert source for each scan:
- internal: the tick-counted pacer issues the converts;
- external: convert pulses supplied on an input are passed through, but only inside a scan and only up to the channel count.

Top module: `scan_pacer`

## Requirements
- R1: With the internal source, the first convert pulse appears on `conv_pulse` in the cycle after the `delay_ticks`-th cycle with `conv_tick` high. Counting starts with the cycle after the one in which the sample pulse was accepted.
- R2: After reset and before any `start_trig`, every `samp_pulse` and `ext_conv` is dropped. Each one raises the matching ignored flag in the next cycle, and no convert pulse is produced.
- R3: A `samp_pulse` that arrives while a scan is in progress is dropped. It raises `samp_ignored` in the next cycle and leaves the timing of the running scan unchanged.
- R4: With the internal source, successive converts of one scan are separated by `period_ticks` ticks. The next convert appears in the cycle after the `period_ticks`-th tick that follows the cycle of the previous convert's issue.
- R5: Each scan issues exactly `num_chan` convert pulses. A `num_chan` of 0 gives one convert pulse.
- R6: `chan_idx` equals k (counted from 0) during the cycle of the k-th convert pulse of a scan. It returns to 0 in the cycle after the final convert.
- R7: `samp_done` is high for exactly the one cycle that carries the final convert pulse of a scan.
- R8: A `delay_ticks` or `period_ticks` value of 0 behaves as 1.
- R9: With the internal source (`conv_src` = 0 when the sample is accepted), every `ext_conv` pulse is dropped and raises `conv_ignored` in the next cycle.
- R10: With the external source (`conv_src` = 1 when the sample is accepted), an `ext_conv` pulse arriving during a scan produces `conv_pulse` in the next cycle, up to the channel count. An `ext_conv` pulse outside a scan, or beyond the count, raises `conv_ignored` instead.
- R11: While `rst` is high, at a clock edge, the block returns to waiting for a trigger. All outputs read 0 in the following cycle, and a scan in progress is abandoned.
- R12: After a scan completes, the next `samp_pulse` starts a new scan without a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_trig | input | 1 | Start trigger pulse; arms the block |
| samp_pulse | input | 1 | Sample-clock pulse |
| conv_tick | input | 1 | Convert timebase tick enable |
| ext_conv | input | 1 | External convert pulse |
| conv_src | input | 1 | Convert source, latched on sample accept: 0 internal, 1 external |
| num_chan | input | CH_W | Channels per scan (0 treated as 1) |
| delay_ticks | input | CNT_W | Ticks from sample to first convert (0 treated as 1) |
| period_ticks | input | CNT_W | Ticks between converts (0 treated as 1) |
| conv_pulse | output | 1 | Convert pulse, one cycle per channel |
| chan_idx | output | CH_W | Channel of the current convert |
| samp_done | output | 1 | High with the last convert of a scan |
| samp_ignored | output | 1 | A sample pulse was dropped in the previous cycle |
| conv_ignored | output | 1 | An external convert pulse was dropped in the previous cycle |

## Verification
The bench places each convert in an exact cycle by counting ticks itself, including with ticks present only every other cycle. An off-by-one in the tick counter, or counting the tick of the accepting cycle, shows up as a convert one tick early or late.

Sample pulses are sent before the trigger, in the middle of a scan, and after reset. A design that restarted on a mid-scan sample would shift every later convert and miss an ignored flag.

Zero delay, zero period and zero channel count are run. A design that did not clamp them would stall or wrap through the full counter range. External converts are sent before, during and beyond a scan, so a design that passes strays or counts past the channel total produces extra convert pulses.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] clamp_min1(input logic [CNT_W-1:0] v);
    return (v == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : v;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= clamp_min1(load_val);
    else if (run && tick && !expire)
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            inc,
  input  logic [CH_W-1:0] total,
  output logic [CH_W-1:0] count,
  output logic            at_last
);
  function automatic logic [CH_W-1:0] last_index(input logic [CH_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  logic [CH_W-1:0] count_q;

  assign count   = count_q;
  assign at_last = (count_q == last_index(total));

  always_ff @(posedge clk) begin
    if (rst || clr)
      count_q <= '0;
    else if (inc)
      count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer
  import scan_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_trig,
  input  logic             samp_pulse,
  input  logic             conv_tick,
  input  logic             ext_conv,
  input  logic             conv_src,
  input  logic [CH_W-1:0]  num_chan,
  input  logic [CNT_W-1:0] delay_ticks,
  input  logic [CNT_W-1:0] period_ticks,
  output logic             conv_pulse,
  output logic [CH_W-1:0]  chan_idx,
  output logic             samp_done,
  output logic             samp_ignored,
  output logic             conv_ignored
);
  seq_state_t      state_q;
  logic            src_q;
  logic [CH_W-1:0] nchan_q;

  // named internal events
  logic idle, armed, busy;
  logic samp_accept, conv_issue, last_conv;
  logic timer_expire, timer_load;
  logic at_last;
  logic [CH_W-1:0]  conv_count;
  logic [CNT_W-1:0] timer_val;

  assign idle  = (state_q == ST_IDLE);
  assign armed = (state_q == ST_ARMED);
  assign busy  = (state_q == ST_RUN);

  assign samp_accept = armed && samp_pulse;
  assign conv_issue  = busy && (src_q ? ext_conv : timer_expire);
  assign last_conv   = conv_issue && at_last;
  assign timer_load  = samp_accept || (timer_expire && !at_last);
  assign timer_val   = samp_accept ? delay_ticks : period_ticks;

  pace_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .run(busy && !src_q), .tick(conv_tick),
    .load(timer_load), .load_val(timer_val), .expire(timer_expire)
  );

  scan_counter #(.CH_W(CH_W)) count_i (
    .clk(clk), .rst(rst), .clr(samp_accept), .inc(conv_issue),
    .total(nchan_q), .count(conv_count), .at_last(at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= 1'b0;
      nchan_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_trig) state_q <= ST_ARMED;
        ST_ARMED: if (samp_pulse) begin
                    state_q <= ST_RUN;
                    src_q   <= conv_src;
                    nchan_q <= num_chan;
                  end
        ST_RUN:   if (last_conv) state_q <= ST_ARMED;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_pulse   <= 1'b0;
      chan_idx     <= '0;
      samp_done    <= 1'b0;
      samp_ignored <= 1'b0;
      conv_ignored <= 1'b0;
    end else begin
      conv_pulse   <= conv_issue;
      samp_done    <= last_conv;
      samp_ignored <= samp_pulse && !armed;
      conv_ignored <= ext_conv && !(busy && src_q);
      if (conv_issue)
        chan_idx <= conv_count;
      else if (samp_done)
        chan_idx <= '0;
    end
  end
endmodule

// File: rtl/scan_pacer_chk.sv
module scan_pacer_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            idle,
  input logic            busy,
  input logic            src_q,
  input logic            samp_pulse,
  input logic            ext_conv,
  input logic            conv_issue,
  input logic            conv_pulse,
  input logic            samp_done,
  input logic [CH_W-1:0] chan_idx,
  input logic            samp_ignored,
  input logic            conv_ignored
);
  p_issue_to_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    conv_issue |=> conv_pulse);

  p_idle_silent_r2: assert property (@(posedge clk) disable iff (rst)
    idle |-> !conv_issue);

  p_mid_scan_samp_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && samp_pulse) |=> samp_ignored);

  p_idx_home_r6: assert property (@(posedge clk) disable iff (rst)
    samp_done |=> (chan_idx == '0));

  p_done_on_conv_r7: assert property (@(posedge clk) disable iff (rst)
    samp_done |-> conv_pulse);

  p_ext_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (ext_conv && !(busy && src_q)) |=> conv_ignored);

  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!conv_pulse && !samp_done && !busy));
endmodule

bind scan_pacer scan_pacer_chk #(.CH_W(CH_W)) chk_i (
  .clk(clk), .rst(rst), .idle(idle), .busy(busy), .src_q(src_q),
  .samp_pulse(samp_pulse), .ext_conv(ext_conv), .conv_issue(conv_issue),
  .conv_pulse(conv_pulse), .samp_done(samp_done), .chan_idx(chan_idx),
  .samp_ignored(samp_ignored), .conv_ignored(conv_ignored)
);

// File: tb/scan_pacer_tb.sv
module scan_pacer_tb_top;
  localparam int CLK_P = 10;
  localparam int CH_W  = 4;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_trig = 0, samp_pulse = 0, conv_tick = 0, ext_conv = 0, conv_src = 0;
  logic [CH_W-1:0]  num_chan = 4;
  logic [CNT_W-1:0] delay_ticks = 3, period_ticks = 2;
  logic conv_pulse, samp_done, samp_ignored, conv_ignored;
  logic [CH_W-1:0] chan_idx;

  int checks = 0, errors = 0;
  int cyc = 0;
  int tick_div = 1;
  int nc = 0, nd = 0, ns = 0, ncg = 0;
  int ct [32];
  int ci [32];
  int cd [32];

  scan_pacer #(.CH_W(CH_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start_trig(start_trig), .samp_pulse(samp_pulse),
    .conv_tick(conv_tick), .ext_conv(ext_conv), .conv_src(conv_src),
    .num_chan(num_chan), .delay_ticks(delay_ticks), .period_ticks(period_ticks),
    .conv_pulse(conv_pulse), .chan_idx(chan_idx), .samp_done(samp_done),
    .samp_ignored(samp_ignored), .conv_ignored(conv_ignored)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    conv_tick = ((cyc % tick_div) == 0);
    if (conv_pulse && nc < 32) begin
      ct[nc] = cyc; ci[nc] = int'(chan_idx); cd[nc] = int'(samp_done); nc++;
    end
    if (samp_done) nd++;
    if (samp_ignored) ns++;
    if (conv_ignored) ncg++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    nc = 0; nd = 0; ns = 0; ncg = 0;
  endtask

  function automatic int tick_at(input int x);
    return ((x % tick_div) == 0) ? 1 : 0;
  endfunction

  // cycle of the convert issued after 'need' ticks following cycle 'from'
  function automatic int conv_cycle(input int from, input int need);
    int x = from;
    int got = 0;
    while (got < need) begin
      x++;
      got += tick_at(x);
    end
    return x + 1;
  endfunction

  task automatic pulse_trigger();
    start_trig = 1; step(1); start_trig = 0;
  endtask

  task automatic t_reset();
    rst = 1; step(3); rst = 0; step(1);
    check(!conv_pulse && !samp_done && chan_idx == 0 && !samp_ignored && !conv_ignored,
          "R11 outputs zero after reset", int'(conv_pulse), 0);
  endtask

  task automatic t_pre_trigger();
    clear_logs();
    samp_pulse = 1; step(1); samp_pulse = 0;
    ext_conv = 1; step(1); ext_conv = 0;
    step(10);
    check(ns == 1, "R2 sample before trigger flagged", ns, 1);
    check(ncg == 1, "R2 convert before trigger flagged", ncg, 1);
    check(nc == 0, "R2 no convert before trigger", nc, 0);
  endtask

  // internal scan; xs/xe: offsets of a stray sample / stray ext convert (0 = none)
  task automatic t_scan(input string tag, input bit trig, input int n, input int d,
                        input int p, input int xs, input int xe);
    int ne = (n == 0) ? 1 : n;
    int de = (d == 0) ? 1 : d;
    int pe = (p == 0) ? 1 : p;
    int c, exp_t, span;
    conv_src = 0;
    num_chan = CH_W'(n); delay_ticks = CNT_W'(d); period_ticks = CNT_W'(p);
    if (trig) pulse_trigger();
    clear_logs();
    c = cyc;
    span = (de + ne * pe) * tick_div + 6;
    for (int i = 0; i < span; i++) begin
      samp_pulse = (i == 0) || (xs != 0 && i == xs);
      ext_conv   = (xe != 0 && i == xe);
      step(1);
    end
    samp_pulse = 0; ext_conv = 0;
    check(nc == ne, {tag, " R5 convert count"}, nc, ne);
    check(nd == 1, {tag, " R7 one done pulse"}, nd, 1);
    check(ns == (xs != 0 ? 1 : 0), {tag, " R3 mid-scan sample flagged"}, ns, (xs != 0 ? 1 : 0));
    check(ncg == (xe != 0 ? 1 : 0), {tag, " R9 stray ext convert flagged"}, ncg, (xe != 0 ? 1 : 0));
    exp_t = conv_cycle(c, de);
    for (int k = 0; k < ne && k < nc; k++) begin
      check(ct[k] == exp_t, {tag, (k == 0) ? " R1 first convert cycle" : " R4 convert spacing"},
            ct[k], exp_t);
      check(ci[k] == k, {tag, " R6 channel index"}, ci[k], k);
      check(cd[k] == ((k == ne - 1) ? 1 : 0), {tag, " R7 done on final convert"},
            cd[k], (k == ne - 1) ? 1 : 0);
      exp_t = conv_cycle(exp_t - 1, pe);
    end
    check(chan_idx == 0, {tag, " R6 index back to zero"}, int'(chan_idx), 0);
  endtask

  task automatic t_ext_mode();
    int c;
    conv_src = 1; num_chan = 2;
    clear_logs();
    ext_conv = 1; step(1); ext_conv = 0;
    c = cyc;
    for (int i = 0; i < 12; i++) begin
      samp_pulse = (i == 0);
      ext_conv   = (i == 3) || (i == 5) || (i == 7);
      step(1);
    end
    samp_pulse = 0; ext_conv = 0; step(2);
    check(nc == 2, "R10 external converts passed", nc, 2);
    check(ncg == 2, "R10 strays outside scan flagged", ncg, 2);
    check(nc >= 1 && ct[0] == c + 4, "R10 first external convert cycle", ct[0], c + 4);
    check(nc >= 2 && ct[1] == c + 6, "R10 second external convert cycle", ct[1], c + 6);
    check(nd == 1, "R7 done in external mode", nd, 1);
    conv_src = 0;
  endtask

  task automatic t_reset_mid();
    conv_src = 0; num_chan = 4; delay_ticks = 3; period_ticks = 4;
    samp_pulse = 1; step(1); samp_pulse = 0;
    step(5);
    rst = 1; step(1); rst = 0;
    clear_logs();
    step(1);
    samp_pulse = 1; step(1); samp_pulse = 0;
    step(30);
    check(nc == 0, "R11 scan abandoned on reset", nc, 0);
    check(ns == 1, "R11 sample after reset needs trigger", ns, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_pre_trigger();
    t_scan("base", 1, 4, 3, 2, 0, 0);
    t_scan("R12 rescan", 0, 3, 2, 3, 0, 0);
    t_scan("stray", 0, 4, 3, 3, 2, 4);
    t_scan("R8 zeros", 0, 0, 0, 0, 0, 0);
    t_scan("R8 zero delay", 0, 3, 0, 0, 0, 0);
    tick_div = 2;
    t_scan("gapped", 0, 4, 3, 2, 0, 0);
    tick_div = 1;
    t_ext_mode();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule